// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This combinational block serves the special-case path of a binary floating-point operation. It is used when at least one of the two operands is a NaN. The operands are IEEE single or double precision words. The block classifies each operand as a number, a quiet NaN or a signaling NaN. It raises an invalid flag whenever either operand is signaling. It then produces the NaN result. In default-NaN mode that result is a fixed canonical NaN. Otherwise it is one of the two operands, chosen under one of four selectable policies, and a signaling operand is quieted on its way out.

A polarity input decides which value of the most significant fraction bit marks a signaling NaN. The same input fixes how a NaN is quieted and which canonical default NaN is produced. When neither operand is a NaN, the result is not defined, and callers must not rely on it.

Top module: `nan_pick_unit`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. With `sig_msb_hi`=0, a NaN whose fraction MSB (bit 22 single, bit 51 double) is 0 is signaling. With `sig_msb_hi`=1, a NaN whose fraction MSB is 1 is signaling. Every other NaN is quiet.
- R2: `invalid` is 1 exactly when at least one operand is a signaling NaN. This also holds in default-NaN mode.
- R3: With `dnan_mode`=1, `result` is the default NaN whatever the operands are. The default NaN has sign 0 and an all-ones exponent. Its fraction is the MSB alone when `sig_msb_hi`=0, and every fraction bit except the MSB when `sig_msb_hi`=1. In single format this gives 0x7FC00000 or 0x7FBFFFFF. In double format it gives 0x7FF8000000000000 or 0x7FF7FFFFFFFFFFFF.
- R4: With `policy_sel`=0, the chosen operand is the first match in this list: A if signaling, B if signaling, A if quiet, otherwise B.
- R5: With `policy_sel`=1, the chosen operand is A if A is any NaN, otherwise B.
- R6: With `policy_sel`=2, the chosen operand is B if B is any NaN, otherwise A.
- R7: With `policy_sel`=3, a NaN paired with a non-NaN yields the NaN, and a signaling NaN paired with a quiet NaN yields the quiet one. Two NaNs of the same kind are settled by magnitude (R8).
- R8: The magnitude tie-break chooses the operand whose word, with the sign bit removed, is larger. If the two magnitudes are equal, it chooses the positive operand. If both signs are also equal, it chooses B.
- R9: A chosen quiet operand is returned unchanged. A chosen signaling operand is quieted before it is returned. With `sig_msb_hi`=0, quieting sets the fraction MSB. With `sig_msb_hi`=1, quieting clears the fraction MSB and sets the bit below it.
- R10: With `fmt_dbl`=0 (single), only bits 31:0 of each operand are used, and `result[63:32]` is 0. With `fmt_dbl`=1, all 64 bits are used.
- R11: The block holds no state. Both outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | First operand (single precision in bits 31:0) |
| op_b | input | 64 | Second operand (single precision in bits 31:0) |
| fmt_dbl | input | 1 | 1 selects double precision, 0 selects single |
| policy_sel | input | 2 | Operand-choice policy, 0 to 3 |
| dnan_mode | input | 1 | 1 forces the default NaN result |
| sig_msb_hi | input | 1 | 1 means a set fraction MSB marks a signaling NaN |
| result | output | 64 | Propagated NaN |
| invalid | output | 1 | At least one operand is a signaling NaN |

## Verification
Two functions can fall in the same cycle: raising the invalid flag and overriding the result with the default NaN. They collide whenever a signaling operand arrives in default-NaN mode. The bench drives that case on purpose, in both formats and both polarities. It also reaches the case at random by mixing signaling NaNs into the stimulus while `dnan_mode` toggles. Each cycle it expects the flag to stay raised while the result equals the canonical default, so neither function may mask the other. A second collision is quieting combined with the tie-break: operands of equal magnitude and opposite sign are driven as signaling pairs, and the bench expects the positive operand, quieted.

// File: rtl/nanp_pkg.sv
package nanp_pkg;

  localparam int WORD_W = 64;
  localparam int NFMT   = 2;
  localparam int SP_W   = 32;

  typedef enum logic [1:0] {
    CLS_NUM  = 2'd0,
    CLS_QNAN = 2'd1,
    CLS_SNAN = 2'd2
  } nan_cls_e;

  typedef enum logic [1:0] {
    PICK_ORDERED   = 2'd0,
    PICK_FIRST     = 2'd1,
    PICK_SECOND    = 2'd2,
    PICK_MAGNITUDE = 2'd3
  } pick_pol_e;

  // Format index 0 is single, 1 is double.
  function automatic int fmt_width(input int f);
    return (f == 0) ? 32 : 64;
  endfunction

  function automatic int fmt_exp(input int f);
    return (f == 0) ? 8 : 11;
  endfunction

endpackage

// File: rtl/nanp_classify.sv
module nanp_classify
  import nanp_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] word,
  input  logic         fmt_dbl,
  input  logic         sig_msb_hi,
  output nan_cls_e     cls,
  output logic [W-2:0] mag,
  output logic         neg
);

  nan_cls_e cls_f [NFMT];

  for (genvar f = 0; f < NFMT; f++) begin : g_fmt
    localparam int FW = fmt_width(f);
    localparam int EW = fmt_exp(f);
    localparam int MW = FW - 1 - EW;
    logic [EW-1:0] ex;
    logic [MW-1:0] fr;
    always_comb begin
      ex = word[FW-2 -: EW];
      fr = word[MW-1:0];
      if (ex != '1 || fr == '0) begin
        cls_f[f] = CLS_NUM;
      end else if (fr[MW-1] == sig_msb_hi) begin
        cls_f[f] = CLS_SNAN;
      end else begin
        cls_f[f] = CLS_QNAN;
      end
    end
  end

  always_comb begin
    cls = fmt_dbl ? cls_f[1] : cls_f[0];
    neg = fmt_dbl ? word[W-1] : word[SP_W-1];
    mag = fmt_dbl ? word[W-2:0] : {{(W-SP_W){1'b0}}, word[SP_W-2:0]};
  end

endmodule

// File: rtl/nanp_choose.sv
module nanp_choose
  import nanp_pkg::*;
(
  input  nan_cls_e  cls_a,
  input  nan_cls_e  cls_b,
  input  pick_pol_e policy,
  input  logic      a_larger,
  output logic      take_b
);

  logic a_nan, b_nan;

  always_comb begin
    a_nan  = (cls_a != CLS_NUM);
    b_nan  = (cls_b != CLS_NUM);
    take_b = 1'b0;
    unique case (policy)
      PICK_ORDERED: begin
        if (cls_a == CLS_SNAN)      take_b = 1'b0;
        else if (cls_b == CLS_SNAN) take_b = 1'b1;
        else if (a_nan)             take_b = 1'b0;
        else                        take_b = 1'b1;
      end
      PICK_FIRST:  take_b = !a_nan;
      PICK_SECOND: take_b = b_nan;
      PICK_MAGNITUDE: begin
        if (!a_nan)                 take_b = 1'b1;
        else if (!b_nan)            take_b = 1'b0;
        else if (cls_a != cls_b)    take_b = (cls_b == CLS_QNAN);
        else                        take_b = !a_larger;
      end
      default: take_b = 1'b0;
    endcase
  end

  // R6
  always_comb begin
    if (policy == PICK_SECOND && cls_b != CLS_NUM) begin
      second_pol_chk: assert (take_b);
    end
  end

endmodule

// File: rtl/nanp_shape.sv
module nanp_shape
  import nanp_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] word,
  input  logic         fmt_dbl,
  input  logic         sig_msb_hi,
  input  logic         is_snan,
  input  logic         dnan_mode,
  output logic [W-1:0] result
);

  logic [W-1:0] shaped_f [NFMT];

  for (genvar f = 0; f < NFMT; f++) begin : g_fmt
    localparam int FW = fmt_width(f);
    localparam int EW = fmt_exp(f);
    localparam int MW = FW - 1 - EW;
    logic [FW-1:0] q;
    logic [FW-1:0] dflt;
    always_comb begin
      q = word[FW-1:0];
      if (is_snan) begin
        if (sig_msb_hi) begin
          q[MW-1] = 1'b0;
          q[MW-2] = 1'b1;
        end else begin
          q[MW-1] = 1'b1;
        end
      end
      dflt            = '0;
      dflt[FW-2 -: EW] = '1;
      if (sig_msb_hi) dflt[MW-2:0] = '1;
      else            dflt[MW-1]   = 1'b1;
      shaped_f[f] = W'(dnan_mode ? dflt : q);
    end
  end

  assign result = fmt_dbl ? shaped_f[1] : shaped_f[0];

endmodule

// File: rtl/nan_pick_unit.sv
module nan_pick_unit
  import nanp_pkg::*;
(
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  input  logic        fmt_dbl,
  input  logic [1:0]  policy_sel,
  input  logic        dnan_mode,
  input  logic        sig_msb_hi,
  output logic [63:0] result,
  output logic        invalid
);

  localparam int W = WORD_W;

  nan_cls_e     cls_a, cls_b;
  logic [W-2:0] mag_a, mag_b;
  logic         neg_a, neg_b;
  logic         a_larger, take_b, sel_snan;
  logic [W-1:0] sel_word;

  nanp_classify #(.W(W)) u_cls_a (
    .word(op_a), .fmt_dbl(fmt_dbl), .sig_msb_hi(sig_msb_hi),
    .cls(cls_a), .mag(mag_a), .neg(neg_a)
  );

  nanp_classify #(.W(W)) u_cls_b (
    .word(op_b), .fmt_dbl(fmt_dbl), .sig_msb_hi(sig_msb_hi),
    .cls(cls_b), .mag(mag_b), .neg(neg_b)
  );

  always_comb begin
    if (mag_a != mag_b) a_larger = (mag_a > mag_b);
    else                a_larger = !neg_a && neg_b;
  end

  nanp_choose u_choose (
    .cls_a(cls_a), .cls_b(cls_b), .policy(pick_pol_e'(policy_sel)),
    .a_larger(a_larger), .take_b(take_b)
  );

  always_comb begin
    sel_word = take_b ? op_b : op_a;
    sel_snan = take_b ? (cls_b == CLS_SNAN) : (cls_a == CLS_SNAN);
    invalid  = (cls_a == CLS_SNAN) || (cls_b == CLS_SNAN);
  end

  nanp_shape #(.W(W)) u_shape (
    .word(sel_word), .fmt_dbl(fmt_dbl), .sig_msb_hi(sig_msb_hi),
    .is_snan(sel_snan), .dnan_mode(dnan_mode), .result(result)
  );

  logic [63:0] a_used;
  logic        any_nan;
  assign a_used  = fmt_dbl ? op_a : {32'h0, op_a[31:0]};
  assign any_nan = (cls_a != CLS_NUM) || (cls_b != CLS_NUM);

  always_comb begin
    // R3
    if (dnan_mode) begin
      dnan_chk: assert (result == (fmt_dbl ?
        (sig_msb_hi ? 64'h7FF7_FFFF_FFFF_FFFF : 64'h7FF8_0000_0000_0000) :
        (sig_msb_hi ? 64'h0000_0000_7FBF_FFFF : 64'h0000_0000_7FC0_0000)));
    end
    // R10
    if (!fmt_dbl) begin
      upper_zero_chk: assert (result[63:32] == 32'h0);
    end
    // R2
    if (invalid) begin
      inv_src_chk: assert (fmt_dbl ? (op_a[62:52] == '1 || op_b[62:52] == '1)
                                   : (op_a[30:23] == '1 || op_b[30:23] == '1));
    end
    // R9
    if (any_nan && !dnan_mode) begin
      quiet_out_chk: assert (fmt_dbl
        ? (result[62:52] == '1 && (sig_msb_hi ? (!result[51] && result[50:0] != '0) : result[51]))
        : (result[30:23] == '1 && (sig_msb_hi ? (!result[22] && result[21:0] != '0) : result[22])));
    end
    // R5
    if (policy_sel == 2'd1 && cls_a == CLS_QNAN && !dnan_mode) begin
      first_pol_chk: assert (result == a_used);
    end
  end

endmodule

// File: tb/nan_pick_unit_bench.sv
`timescale 1ns/1ps
module nan_pick_unit_bench;

  logic        clk;
  logic [63:0] op_a, op_b;
  logic        fmt_dbl, dnan_mode, sig_msb_hi;
  logic [1:0]  policy_sel;
  logic [63:0] result;
  logic        invalid;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  nan_pick_unit u_nan_pick_unit (
    .op_a(op_a), .op_b(op_b), .fmt_dbl(fmt_dbl), .policy_sel(policy_sel),
    .dnan_mode(dnan_mode), .sig_msb_hi(sig_msb_hi),
    .result(result), .invalid(invalid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail = n_fail + 1;
      n_chk  = n_chk + 1;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // Behavioural reference: returns {invalid, result}
  function automatic logic [64:0] ref_pick(input logic [63:0] a, input logic [63:0] b,
                                           input bit dbl, input bit pol, input int pl,
                                           input bit dn);
    logic [63:0] msk, fm, em, aw, bw, ma, mb, sel, res;
    int fr;
    bit na, nb, sa, sb, qa, qb, inv, lg, tb;
    fr  = dbl ? 52 : 23;
    msk = dbl ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    fm  = (64'd1 << fr) - 64'd1;
    em  = (msk >> 1) & ~fm;
    aw  = a & msk;
    bw  = b & msk;
    na  = ((aw & em) == em) && ((aw & fm) != 0);
    nb  = ((bw & em) == em) && ((bw & fm) != 0);
    sa  = na && (aw[fr-1] == pol);
    sb  = nb && (bw[fr-1] == pol);
    qa  = na && !sa;
    qb  = nb && !sb;
    inv = sa || sb;
    ma  = aw & (msk >> 1);
    mb  = bw & (msk >> 1);
    lg  = (ma > mb) || (ma == mb && aw < bw);
    case (pl)
      0: tb = sa ? 1'b0 : sb ? 1'b1 : qa ? 1'b0 : 1'b1;
      1: tb = !na;
      2: tb = nb;
      default: begin
        if (!na)            tb = 1'b1;
        else if (!nb)       tb = 1'b0;
        else if (sa && qb)  tb = 1'b1;
        else if (qa && sb)  tb = 1'b0;
        else                tb = !lg;
      end
    endcase
    sel = tb ? bw : aw;
    if (tb ? sb : sa) begin
      if (pol) begin
        sel[fr-1] = 1'b0;
        sel[fr-2] = 1'b1;
      end else begin
        sel[fr-1] = 1'b1;
      end
    end
    if (dn) res = em | (pol ? (fm >> 1) : (64'd1 << (fr - 1)));
    else    res = sel;
    return {inv, res};
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input bit dbl,
                       input int pl, input bit dn, input bit pol, input string tag);
    logic [64:0] exp_v;
    @(posedge clk);
    #1;
    op_a = a; op_b = b; fmt_dbl = dbl; policy_sel = 2'(pl);
    dnan_mode = dn; sig_msb_hi = pol;
    exp_v = ref_pick(a, b, dbl, pol, pl, dn);
    @(negedge clk);
    n_chk = n_chk + 1;
    if ({invalid, result} !== exp_v) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual inv=%0b res=%h expected inv=%0b res=%h",
               tag, invalid, result, exp_v[64], exp_v[63:0]);
    end
  endtask

  function automatic logic [63:0] rnd_nan(input bit dbl);
    logic [63:0] w;
    w = {$urandom, $urandom};
    if (dbl) begin
      w[62:52] = '1;
      if (w[51:0] == 0) w[0] = 1'b1;
      if (w[50:0] == 0) w[1] = 1'b1;
    end else begin
      w[30:23] = '1;
      if (w[21:0] == 0) w[0] = 1'b1;
    end
    return w;
  endfunction

  localparam logic [63:0] SQ_A = 64'h7FC0_0001;
  localparam logic [63:0] SS_A = 64'h7F80_0005;
  localparam logic [63:0] SQ_B = 64'hFFC0_0002;
  localparam logic [63:0] SS_B = 64'hFF80_0007;
  localparam logic [63:0] SNUM = 64'h3F80_0000;
  localparam logic [63:0] DQ_A = 64'h7FF8_0000_0000_0011;
  localparam logic [63:0] DS_B = 64'hFFF0_0000_0000_0022;

  initial begin
    string tags [4];
    tags[0] = "R4"; tags[1] = "R5"; tags[2] = "R6"; tags[3] = "R7";
    op_a = '0; op_b = '0; fmt_dbl = 1'b0; policy_sel = '0;
    dnan_mode = 1'b0; sig_msb_hi = 1'b0;

    // R1 classification under both polarities
    apply(SQ_A, SNUM, 1'b0, 1, 1'b0, 1'b0, "R1");
    apply(SQ_A, SNUM, 1'b0, 1, 1'b0, 1'b1, "R1");
    apply(SS_A, SNUM, 1'b0, 1, 1'b0, 1'b1, "R1");
    // R2 and R3 together: signaling input in default mode
    apply(SS_A, SQ_B, 1'b0, 0, 1'b1, 1'b0, "R2");
    apply(SQ_A, SS_B, 1'b1, 0, 1'b1, 1'b0, "R2");
    apply(DQ_A, DS_B, 1'b1, 3, 1'b1, 1'b0, "R3");
    apply(DQ_A, DS_B, 1'b1, 3, 1'b1, 1'b1, "R3");
    apply(SNUM, SQ_B, 1'b0, 2, 1'b1, 1'b1, "R3");
    // R4 ordered
    apply(SQ_A, SS_B, 1'b0, 0, 1'b0, 1'b0, "R4");
    apply(SNUM, SQ_B, 1'b0, 0, 1'b0, 1'b0, "R4");
    apply(SS_A, SS_B, 1'b0, 0, 1'b0, 1'b0, "R4");
    // R5 / R6
    apply(SQ_A, SS_B, 1'b0, 1, 1'b0, 1'b0, "R5");
    apply(SNUM, SS_B, 1'b0, 1, 1'b0, 1'b0, "R5");
    apply(SS_A, SQ_B, 1'b0, 2, 1'b0, 1'b0, "R6");
    apply(SQ_A, SNUM, 1'b0, 2, 1'b0, 1'b0, "R6");
    // R7 kinds
    apply(SS_A, SQ_B, 1'b0, 3, 1'b0, 1'b0, "R7");
    apply(SQ_A, SS_B, 1'b0, 3, 1'b0, 1'b0, "R7");
    apply(SNUM, SS_B, 1'b0, 3, 1'b0, 1'b0, "R7");
    // R8 tie-break
    apply(64'h7FC0_0003, 64'hFFC0_0003, 1'b0, 3, 1'b0, 1'b0, "R8");
    apply(64'hFFC0_0003, 64'h7FC0_0003, 1'b0, 3, 1'b0, 1'b0, "R8");
    apply(64'h7F80_0009, 64'hFF80_0009, 1'b0, 3, 1'b0, 1'b0, "R8");
    apply(64'hFFC0_0010, 64'h7FC0_0002, 1'b0, 3, 1'b0, 1'b0, "R8");
    apply(64'h7FC0_0003, 64'h7FC0_0003, 1'b0, 3, 1'b0, 1'b0, "R8");
    // R9 quieting, both polarities and formats
    apply(SS_A, SNUM, 1'b0, 1, 1'b0, 1'b0, "R9");
    apply(SQ_A, SNUM, 1'b0, 1, 1'b0, 1'b1, "R9");
    apply(SNUM, DS_B, 1'b1, 2, 1'b0, 1'b0, "R9");
    apply(64'h7FFC_0000_0000_0000, SNUM, 1'b1, 1, 1'b0, 1'b1, "R9");
    // R10 single format ignores upper bits
    apply(64'hDEAD_BEEF_7FC0_0001, 64'h1234_5678_3F80_0000, 1'b0, 1, 1'b0, 1'b0, "R10");
    apply(64'h7FF0_0000_0000_0001, SQ_B, 1'b0, 0, 1'b0, 1'b0, "R10");
    apply(64'h7FF0_0000_0000_0001, SQ_B, 1'b1, 0, 1'b0, 1'b0, "R10");

    // R11 same-cycle response over mixed random stimulus
    for (int i = 0; i < 2000; i++) begin
      bit dbl, pol, dn;
      int pl, kind;
      logic [63:0] a, b;
      dbl  = $urandom_range(0, 1) != 0;
      pol  = $urandom_range(0, 1) != 0;
      dn   = $urandom_range(0, 5) == 0;
      pl   = $urandom_range(0, 3);
      kind = $urandom_range(0, 5);
      a = rnd_nan(dbl);
      b = rnd_nan(dbl);
      if (kind == 0) a = {$urandom, $urandom} & 64'h3FFF_FFFF_3FFF_FFFF;
      if (kind == 1) b = {$urandom, $urandom} & 64'h3FFF_FFFF_3FFF_FFFF;
      if (kind == 2) b = a ^ (dbl ? 64'h8000_0000_0000_0000 : 64'h8000_0000);
      if (kind == 3) b = a;
      apply(a, b, dbl, pl, dn, pol, dn ? "R3" : (i % 2 == 0) ? tags[pl] : "R11");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule